// File: doc/BRIEF.md
# Fault Protection and Restart Sequencer

This block supervises an off-line switching power controller. It steps the controller from supply under-voltage lockout through a fixed-length soft start into normal regulation. While the controller is powered it watches a set of comparator flags and sorts every fault into one of two responses: an automatic restart through a fresh supply charge-up, or a latched shutdown. A latched shutdown is held until the supply collapses well below the lockout level.

An overload does not act at once. Feedback must stay high for a fixed blanking interval counted in clock ticks. After that, the block asks an external current source to ramp the blanking pin, and it acts only when that pin passes its upper threshold. If feedback falls during either stage, the overload is forgotten and regulation goes on. All analog sensing lies outside the block, which sees only threshold flags. The tick counts are parameters, so that simulation can use short timers.

Top module: `fault_restart_seq`

## Requirements
- R1: After reset, `state` is 0 (lockout), `startup_cell_on` is 1, and `reference_on`, `switching_enable` and `soft_start_active` are 0. The state codes are 0 lockout, 1 soft start, 2 run, 3 fixed blank, 4 ramp blank, 5 restart wait and 6 latched.
- R2: In lockout, `vcc_above_on` moves the block to soft start on the next clock edge. From that edge the startup cell is off and the reference and switching are on.
- R3: Soft start lasts exactly SS_TICKS clock cycles with `soft_start_active` high, and is then followed by run (state 2).
- R4: In any powered state (1 to 4), `vcc_below_off` with no latched fault returns the block to lockout on the next edge. Switching stops and the startup cell turns on.
- R5: In a powered state, `temp_over`, `cs_over`, `blk_low`, or `vcc_above_ovp` together with `fb_high`, moves the block to latched (state 6) on the next edge. Reference and switching go off there.
- R6: `vcc_above_ovp` without `fb_high` has no effect in run.
- R7: While latched, `vcc_below_off` turns the startup cell on and `vcc_above_on` turns it off. Neither of them, nor a removed fault, leaves the latched state.
- R8: The latched state is left only through `vcc_below_clr`, which leads to lockout on the next edge.
- R9: In run, `fb_high` starts the fixed blank (state 3). The fixed blank lasts BLANK_TICKS cycles, then the ramp blank (state 4) raises `ext_blank_charge`. `blk_high` then moves the block to restart wait (state 5).
- R10: If `fb_high` drops during either blank stage, the block returns to run on the next edge with `ext_blank_charge` low.
- R11: In restart wait, switching, reference and the startup cell are all off until `vcc_below_off` gives lockout. A new startup then re-checks the overload after soft start and starts a new blank if the overload is still present.
- R12: When a latched fault occurs in the same cycle as an under-voltage or an overload, the latched response wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_above_on | input | 1 | Supply above turn-on level |
| vcc_below_off | input | 1 | Supply below turn-off level |
| vcc_below_clr | input | 1 | Supply below latch-clear level |
| vcc_above_ovp | input | 1 | Supply above over-voltage level |
| fb_high | input | 1 | Feedback above overload level |
| cs_over | input | 1 | Current sense above winding-short level |
| temp_over | input | 1 | Junction over temperature |
| blk_low | input | 1 | Blanking pin pulled below its low threshold |
| blk_high | input | 1 | Blanking pin ramp above its upper threshold |
| startup_cell_on | output | 1 | Enables the high-voltage startup current source |
| reference_on | output | 1 | Enables the internal reference |
| soft_start_active | output | 1 | Soft start in progress |
| switching_enable | output | 1 | Gate drive allowed |
| ext_blank_charge | output | 1 | Request to charge the blanking pin |
| state | output | 3 | Sequencer state code |

## Verification
Every output is decoded from a registered state. A flag change therefore shows on the outputs one clock edge after it is applied. The two timed stages are the exception: they take SS_TICKS and BLANK_TICKS edges. The bench changes inputs just after a falling edge and reads results at the following falling edge, so each check lands exactly one edge after its stimulus. The timed stages are measured by counting falling-edge samples while the state holds, and the count is compared with the parameter.

// File: rtl/fault_restart_seq.sv
module fault_restart_seq #(
  parameter int SS_TICKS    = 1000000,
  parameter int BLANK_TICKS = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_above_on,
  input  logic       vcc_below_off,
  input  logic       vcc_below_clr,
  input  logic       vcc_above_ovp,
  input  logic       fb_high,
  input  logic       cs_over,
  input  logic       temp_over,
  input  logic       blk_low,
  input  logic       blk_high,
  output logic       startup_cell_on,
  output logic       reference_on,
  output logic       soft_start_active,
  output logic       switching_enable,
  output logic       ext_blank_charge,
  output logic [2:0] state
);

  localparam int MAXT = (SS_TICKS > BLANK_TICKS) ? SS_TICKS : BLANK_TICKS;
  localparam int CW   = (MAXT > 1) ? $clog2(MAXT) : 1;
  localparam logic [CW-1:0] SS_LAST = CW'(SS_TICKS - 1);
  localparam logic [CW-1:0] BL_LAST = CW'(BLANK_TICKS - 1);

  typedef enum logic [2:0] {
    S_UVLO  = 3'd0,
    S_SOFT  = 3'd1,
    S_RUN   = 3'd2,
    S_BFIX  = 3'd3,
    S_BRAMP = 3'd4,
    S_RWAIT = 3'd5,
    S_LATCH = 3'd6
  } st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          lat_chg, lat_chg_nx;
  logic          powered, latch_trip;

  assign powered    = (st == S_SOFT) || (st == S_RUN) || (st == S_BFIX) || (st == S_BRAMP);
  assign latch_trip = temp_over | cs_over | blk_low | (vcc_above_ovp & fb_high);

  always_comb begin
    st_nx      = st;
    cnt_nx     = cnt;
    lat_chg_nx = lat_chg;
    if (powered && latch_trip) begin
      st_nx      = S_LATCH;
      lat_chg_nx = 1'b0;
    end else if (powered && vcc_below_off) begin
      st_nx = S_UVLO;
    end else begin
      case (st)
        S_UVLO: if (vcc_above_on) begin
          st_nx  = S_SOFT;
          cnt_nx = '0;
        end
        S_SOFT: if (cnt == SS_LAST) st_nx = S_RUN;
                else cnt_nx = cnt + 1'b1;
        S_RUN: if (fb_high) begin
          st_nx  = S_BFIX;
          cnt_nx = '0;
        end
        S_BFIX: if (!fb_high) st_nx = S_RUN;
                else if (cnt == BL_LAST) st_nx = S_BRAMP;
                else cnt_nx = cnt + 1'b1;
        S_BRAMP: if (!fb_high) st_nx = S_RUN;
                 else if (blk_high) st_nx = S_RWAIT;
        S_RWAIT: if (vcc_below_off) st_nx = S_UVLO;
        S_LATCH: if (vcc_below_clr) begin
          st_nx      = S_UVLO;
          lat_chg_nx = 1'b0;
        end else if (vcc_below_off) lat_chg_nx = 1'b1;
        else if (vcc_above_on) lat_chg_nx = 1'b0;
        default: st_nx = S_UVLO;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_UVLO;
      cnt     <= '0;
      lat_chg <= 1'b0;
    end else begin
      st      <= st_nx;
      cnt     <= cnt_nx;
      lat_chg <= lat_chg_nx;
    end
  end

  assign startup_cell_on   = (st == S_UVLO) || ((st == S_LATCH) && lat_chg);
  assign reference_on      = powered;
  assign switching_enable  = powered;
  assign soft_start_active = (st == S_SOFT);
  assign ext_blank_charge  = (st == S_BRAMP);
  assign state             = st;

endmodule

// File: rtl/fault_restart_seq_chk.sv
module fault_restart_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vcc_above_on,
  input logic       vcc_below_off,
  input logic       vcc_below_clr,
  input logic       vcc_above_ovp,
  input logic       fb_high,
  input logic       cs_over,
  input logic       temp_over,
  input logic       blk_low,
  input logic       blk_high,
  input logic       startup_cell_on,
  input logic       reference_on,
  input logic       soft_start_active,
  input logic       switching_enable,
  input logic       ext_blank_charge,
  input logic [2:0] state
);

  logic trip, blanking;
  assign trip     = temp_over | cs_over | blk_low | (vcc_above_ovp & fb_high);
  assign blanking = (state == 3'd3) || (state == 3'd4);

  // R2
  startup_to_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && vcc_above_on) |=> (soft_start_active && !startup_cell_on));

  // R4
  undervolt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (switching_enable && vcc_below_off && !trip) |=> (state == 3'd0 && startup_cell_on));

  // R5
  latch_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (switching_enable && trip) |=> (state == 3'd6 && !reference_on && !switching_enable));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd6 && !vcc_below_clr) |=> (state == 3'd6));

  // R8
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd6 && vcc_below_clr) |=> (state == 3'd0));

  // R9
  ramp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && fb_high && blk_high && !trip && !vcc_below_off) |=> (state == 3'd5));

  // R10
  blank_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blanking && !fb_high && !trip && !vcc_below_off) |=> (state == 3'd2 && !ext_blank_charge));

  // R11
  restart_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd5) |-> (!switching_enable && !startup_cell_on && !reference_on));

endmodule

bind fault_restart_seq fault_restart_seq_chk u_chk (.*);

// File: tb/fault_restart_seq_tb.sv
module fault_restart_seq_tb;
  localparam int SS = 16;
  localparam int BL = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vcc_above_on = 0, vcc_below_off = 1, vcc_below_clr = 1, vcc_above_ovp = 0;
  logic fb_high = 0, cs_over = 0, temp_over = 0, blk_low = 0, blk_high = 0;
  logic startup_cell_on, reference_on, soft_start_active, switching_enable, ext_blank_charge;
  logic [2:0] state;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fault_restart_seq #(.SS_TICKS(SS), .BLANK_TICKS(BL)) u_dut (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic clear_faults();
    vcc_above_ovp = 0; fb_high = 0; cs_over = 0; temp_over = 0; blk_low = 0; blk_high = 0;
  endtask

  task automatic go_off();
    clear_faults();
    vcc_below_clr = 1; vcc_below_off = 1; vcc_above_on = 0;
    tick();
    check("R8 back to lockout", state, 0);
  endtask

  task automatic go_run();
    vcc_below_clr = 0; vcc_below_off = 0; vcc_above_on = 1;
    tick();
    repeat (SS) tick();
    check("R3 run reached", state, 2);
  endtask

  task automatic t_reset();
    check("R1 state", state, 0);
    check("R1 startup cell", startup_cell_on, 1);
    check("R1 switching", switching_enable, 0);
    check("R1 reference", reference_on, 0);
  endtask

  task automatic t_softstart();
    int n = 0;
    vcc_below_clr = 0; vcc_below_off = 0; vcc_above_on = 1;
    tick();
    check("R2 soft state", state, 1);
    check("R2 startup off", startup_cell_on, 0);
    check("R2 switching on", switching_enable, 1);
    while (soft_start_active && n < 1000) begin n++; tick(); end
    check("R3 soft length", n, SS);
    check("R3 then run", state, 2);
  endtask

  task automatic t_undervolt();
    go_run();
    vcc_above_on = 0; vcc_below_off = 1;
    tick();
    check("R4 lockout", state, 0);
    check("R4 startup on", startup_cell_on, 1);
    check("R4 switching off", switching_enable, 0);
  endtask

  task automatic t_latch_causes();
    for (int c = 0; c < 4; c++) begin
      go_off();
      go_run();
      case (c)
        0: temp_over = 1;
        1: cs_over = 1;
        2: blk_low = 1;
        default: begin vcc_above_ovp = 1; fb_high = 1; end
      endcase
      tick();
      check($sformatf("R5 latched cause %0d", c), state, 6);
      check($sformatf("R5 reference off cause %0d", c), reference_on, 0);
      check($sformatf("R5 switching off cause %0d", c), switching_enable, 0);
    end
  endtask

  task automatic t_ovp_alone();
    go_off(); go_run();
    vcc_above_ovp = 1;
    repeat (3) tick();
    check("R6 ovp alone ignored", state, 2);
    check("R6 switching kept", switching_enable, 1);
    vcc_above_ovp = 0;
  endtask

  task automatic t_latch_hold_clear();
    go_off(); go_run();
    temp_over = 1; tick();
    temp_over = 0; tick();
    check("R7 fault removed still latched", state, 6);
    check("R7 startup off", startup_cell_on, 0);
    vcc_above_on = 0; vcc_below_off = 1; tick();
    check("R7 startup on below off", startup_cell_on, 1);
    check("R7 still latched", state, 6);
    vcc_above_on = 1; vcc_below_off = 0; tick();
    check("R7 startup off above on", startup_cell_on, 0);
    check("R7 no restart", state, 6);
    check("R7 no switching", switching_enable, 0);
    vcc_above_on = 0; vcc_below_off = 1; vcc_below_clr = 1; tick();
    check("R8 cleared to lockout", state, 0);
    check("R8 startup on", startup_cell_on, 1);
  endtask

  task automatic t_overload_restart();
    int n = 0;
    go_off(); go_run();
    fb_high = 1; tick();
    check("R9 fixed blank", state, 3);
    while (state == 3 && n < 1000) begin n++; tick(); end
    check("R9 fixed blank length", n, BL);
    check("R9 ramp blank", state, 4);
    check("R9 ramp request", ext_blank_charge, 1);
    repeat (5) tick();
    check("R9 waits for ramp", state, 4);
    blk_high = 1; tick();
    check("R9 restart wait", state, 5);
    check("R11 switching off", switching_enable, 0);
    check("R11 startup off", startup_cell_on, 0);
    blk_high = 0; repeat (3) tick();
    check("R11 holds waiting", state, 5);
    vcc_above_on = 0; vcc_below_off = 1; tick();
    check("R11 lockout", state, 0);
    vcc_above_on = 1; vcc_below_off = 0; tick();
    check("R11 new soft start", state, 1);
    repeat (SS) tick();
    check("R11 run after soft", state, 2);
    tick();
    check("R11 overload rechecked", state, 3);
    fb_high = 0; tick();
    check("R10 abort fixed blank", state, 2);
  endtask

  task automatic t_ramp_abort();
    fb_high = 1; tick();
    repeat (BL) tick();
    check("R10 in ramp", state, 4);
    fb_high = 0; tick();
    check("R10 abort ramp", state, 2);
    check("R10 ramp request off", ext_blank_charge, 0);
  endtask

  task automatic t_priority();
    go_off(); go_run();
    cs_over = 1; fb_high = 1; vcc_above_on = 0; vcc_below_off = 1;
    tick();
    check("R12 latch beats uv and overload", state, 6);
    go_off(); go_run();
    fb_high = 1; tick();
    blk_low = 1; tick();
    check("R12 latch during blank", state, 6);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_softstart();
    t_undervolt();
    t_latch_causes();
    t_ovp_alone();
    t_latch_hold_clear();
    t_overload_restart();
    t_ramp_abort();
    t_priority();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all-requirements actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule